// File: doc/BRIEF.md
# Embedded-Sync Video Input Formatter

This block takes a 4:2:2 component video stream and turns it into three parallel 10-bit channels (luma, blue-difference, red-difference), each with a valid strobe. It also produces a uniform set of horizontal, vertical and field timing flags. A mode pin picks the timing source. In embedded mode, a single multiplexed word stream carries the samples, and timing reference codes are inserted among them. The block finds these codes and decodes the flags from them. In external mode, a parallel luma bus and a chroma bus arrive alongside three dedicated sync pins, and those pins supply the flags.

Both modes accept 10-bit samples or 8-bit samples. 8-bit samples are widened to the 10-bit internal form. Chroma is brought to 4:4:4 by repeating each colour-difference pair on the two luma samples it belongs to. When the protection bits of a timing code are inconsistent, the flags are left untouched and an error pulse is reported.

Top module: `embsync_fmt`

## Requirements
- R1: In embedded mode a timing code is four consecutive words: upper eight bits all ones, then upper eight all zeros, again all zeros, then a status word. In the status word, bit 9 must be 1; F is bit 8, V is bit 7 and H is bit 6; bits 5..2 are protection bits equal to {V^H, F^H, F^V, F^V^H}. A valid code updates f_flag/v_flag/h_flag at the clock edge where the status word is sampled.
- R2: When `narrow` is 1, the block uses only bits 7..0 of each input word and treats them as bits 9..2 of a 10-bit sample whose bits 1..0 are zero. Input bits 9..8 are ignored. Code detection, flag decoding and the channel outputs all work on this widened form.
- R3: After a code, the embedded words arrive in the order Cb, Y0, Cr, Y1. The block emits (Y0, Cb, Cr) when Cr is consumed and then (Y1, Cb, Cr) when Y1 is consumed. All three valid strobes are high together for each emitted pixel.
- R4: None of the four code words is ever presented as a valid output sample.
- R5: A status word whose protection bits (or bit 9) are inconsistent leaves the flags unchanged. It also raises prot_err for exactly one cycle.
- R6: Each code restarts the Cb, Y0, Cr, Y1 order. A pair cut short by a code is not completed: with two words consumed nothing is emitted, and with three words only (Y0, Cb, Cr) is emitted.
- R7: In external mode the flags are the ext_f/ext_v/ext_h pins registered once. mux_data is not searched for codes, and prot_err stays 0.
- R8: In external mode, while ext_h is 0, each cycle supplies one luma sample. Chroma alternates Cb then Cr, starting with Cb on the first such cycle. (Y0, Cb, Cr) appears one cycle after the Cr cycle, and (Y1, Cb, Cr) appears in the following cycle, including the cycle in which h_flag rises. A trailing Cb sample with no Cr is dropped.
- R9: In embedded mode the ext_f/ext_v/ext_h pins have no effect on the flags.
- R10: While reset is held, every channel output, strobe, flag and prot_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 0: embedded codes, 1: external sync pins |
| narrow | input | 1 | 1: 8-bit samples on bits 7..0 |
| mux_data | input | 10 | Multiplexed Cb/Y/Cr/Y stream with timing codes |
| luma_in | input | 10 | Parallel luma bus (external mode) |
| chroma_in | input | 10 | Parallel alternating Cb/Cr bus (external mode) |
| ext_h | input | 1 | External horizontal blanking pin |
| ext_v | input | 1 | External vertical blanking pin |
| ext_f | input | 1 | External field pin |
| y_out | output | 10 | Luma channel |
| cb_out | output | 10 | Blue-difference channel |
| cr_out | output | 10 | Red-difference channel |
| y_vld | output | 1 | Luma sample valid |
| cb_vld | output | 1 | Blue-difference sample valid |
| cr_vld | output | 1 | Red-difference sample valid |
| h_flag | output | 1 | Horizontal timing flag |
| v_flag | output | 1 | Vertical timing flag |
| f_flag | output | 1 | Field flag |
| prot_err | output | 1 | One-cycle pulse on a bad status word |

## Verification
In external mode, the last luma sample of a line is emitted at the same clock edge that registers the rising ext_h. The bench ends every active run and then samples the next cycle. There it requires both h_flag high and a valid pixel, and the monitor compares that pixel against the held chroma pair. In embedded mode, a timing code and the end of a pixel pair compete for the same consumption slot. The bench places codes after two-word and three-word partial pairs and expects exactly the emissions that R6 allows. A code carrying bad protection bits must pulse prot_err without moving the flags.

// File: rtl/efi_pkg.sv
package efi_pkg;
  localparam int SAMP_W   = 10;
  localparam int NARROW_W = 8;
  localparam int PAD_W    = SAMP_W - NARROW_W;
  localparam int PRE_LEN  = 3;

  typedef logic [SAMP_W-1:0] samp_t;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tflag_t;

  typedef struct packed {
    samp_t y;
    samp_t cb;
    samp_t cr;
  } pix_t;

  // Place an 8-bit sample in the upper bits of the 10-bit internal form
  function automatic samp_t widen(input samp_t d, input logic nar);
    return nar ? {d[NARROW_W-1:0], {PAD_W{1'b0}}} : d;
  endfunction

  function automatic logic top_ones(input samp_t s);
    return &s[SAMP_W-1:PAD_W];
  endfunction

  function automatic logic top_zero(input samp_t s);
    return ~|s[SAMP_W-1:PAD_W];
  endfunction

  function automatic tflag_t status_flags(input samp_t s);
    tflag_t t;
    t.f = s[8];
    t.v = s[7];
    t.h = s[6];
    return t;
  endfunction

  function automatic logic [3:0] prot_of(input tflag_t t);
    return {t.v ^ t.h, t.f ^ t.h, t.f ^ t.v, t.f ^ t.v ^ t.h};
  endfunction

  function automatic logic status_ok(input samp_t s);
    return s[9] && (s[5:2] == prot_of(status_flags(s)));
  endfunction
endpackage

// File: rtl/efi_code_scan.sv
module efi_code_scan
  import efi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  samp_t  din,
  output logic   hit,
  output logic   take,
  output samp_t  word,
  output tflag_t flags,
  output logic   err
);
  samp_t p [PRE_LEN];
  logic  t [PRE_LEN];
  logic  zeros;

  always_comb begin
    zeros = 1'b1;
    for (int i = 0; i < PRE_LEN - 1; i++) zeros = zeros & top_zero(p[i]);
    hit = en & top_ones(p[PRE_LEN-1]) & zeros;
  end

  assign take = t[PRE_LEN-1] & ~hit;
  assign word = p[PRE_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) begin
        p[i] <= '0;
        t[i] <= 1'b0;
      end
      flags <= '0;
      err   <= 1'b0;
    end else begin
      p[0] <= din;
      t[0] <= en & ~hit;
      for (int i = 1; i < PRE_LEN; i++) begin
        p[i] <= p[i-1];
        t[i] <= t[i-1] & ~hit;
      end
      err <= hit & ~status_ok(din);
      if (hit && status_ok(din)) flags <= status_flags(din);
    end
  end
endmodule

// File: rtl/efi_pair_embed.sv
module efi_pair_embed
  import efi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  realign,
  input  logic  take,
  input  samp_t word,
  output pix_t  pix,
  output logic  vld
);
  logic [1:0] phase;
  samp_t      cb_h, cr_h, y0_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0;
      cb_h  <= '0;
      cr_h  <= '0;
      y0_h  <= '0;
      pix   <= '0;
      vld   <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (realign) begin
        phase <= 2'd0;
      end else if (take) begin
        phase <= phase + 2'd1;
        case (phase)
          2'd0: cb_h <= word;
          2'd1: y0_h <= word;
          2'd2: begin
            cr_h <= word;
            pix  <= '{y: y0_h, cb: cb_h, cr: word};
            vld  <= 1'b1;
          end
          default: begin
            pix <= '{y: word, cb: cb_h, cr: cr_h};
            vld <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/efi_ext_path.sv
module efi_ext_path
  import efi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  samp_t  luma,
  input  samp_t  chroma,
  input  logic   eh,
  input  logic   ev,
  input  logic   ef,
  output pix_t   pix,
  output logic   vld,
  output tflag_t flags
);
  logic  odd, pend;
  samp_t ya, y1, cb_h, cr_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd   <= 1'b0;
      pend  <= 1'b0;
      ya    <= '0;
      y1    <= '0;
      cb_h  <= '0;
      cr_h  <= '0;
      pix   <= '0;
      vld   <= 1'b0;
      flags <= '0;
    end else begin
      vld   <= 1'b0;
      flags <= '{f: ef, v: ev, h: eh};
      if (!en) begin
        odd  <= 1'b0;
        pend <= 1'b0;
      end else if (eh) begin
        odd <= 1'b0;
        if (pend) begin
          pix  <= '{y: y1, cb: cb_h, cr: cr_h};
          vld  <= 1'b1;
          pend <= 1'b0;
        end
      end else if (!odd) begin
        if (pend) begin
          pix  <= '{y: y1, cb: cb_h, cr: cr_h};
          vld  <= 1'b1;
          pend <= 1'b0;
        end
        ya   <= luma;
        cb_h <= chroma;
        odd  <= 1'b1;
      end else begin
        pix  <= '{y: ya, cb: cb_h, cr: chroma};
        vld  <= 1'b1;
        cr_h <= chroma;
        y1   <= luma;
        pend <= 1'b1;
        odd  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/embsync_fmt.sv
module embsync_fmt
  import efi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              narrow,
  input  logic [SAMP_W-1:0] mux_data,
  input  logic [SAMP_W-1:0] luma_in,
  input  logic [SAMP_W-1:0] chroma_in,
  input  logic              ext_h,
  input  logic              ext_v,
  input  logic              ext_f,
  output logic [SAMP_W-1:0] y_out,
  output logic [SAMP_W-1:0] cb_out,
  output logic [SAMP_W-1:0] cr_out,
  output logic              y_vld,
  output logic              cb_vld,
  output logic              cr_vld,
  output logic              h_flag,
  output logic              v_flag,
  output logic              f_flag,
  output logic              prot_err
);
  samp_t  mux_w, luma_w, chroma_w, emb_word;
  logic   code_hit, emb_take, emb_vld, ext_vld;
  pix_t   emb_pix, ext_pix, sel_pix;
  tflag_t emb_flags, ext_flags, sel_flags;

  assign mux_w    = widen(mux_data, narrow);
  assign luma_w   = widen(luma_in, narrow);
  assign chroma_w = widen(chroma_in, narrow);

  efi_code_scan u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~sync_mode),
    .din   (mux_w),
    .hit   (code_hit),
    .take  (emb_take),
    .word  (emb_word),
    .flags (emb_flags),
    .err   (prot_err)
  );

  efi_pair_embed u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (code_hit),
    .take    (emb_take),
    .word    (emb_word),
    .pix     (emb_pix),
    .vld     (emb_vld)
  );

  efi_ext_path u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (sync_mode),
    .luma   (luma_w),
    .chroma (chroma_w),
    .eh     (ext_h),
    .ev     (ext_v),
    .ef     (ext_f),
    .pix    (ext_pix),
    .vld    (ext_vld),
    .flags  (ext_flags)
  );

  assign sel_pix   = sync_mode ? ext_pix : emb_pix;
  assign sel_flags = sync_mode ? ext_flags : emb_flags;

  assign y_out  = sel_pix.y;
  assign cb_out = sel_pix.cb;
  assign cr_out = sel_pix.cr;
  assign y_vld  = sync_mode ? ext_vld : emb_vld;
  assign cb_vld = y_vld;
  assign cr_vld = y_vld;
  assign h_flag = sel_flags.h;
  assign v_flag = sel_flags.v;
  assign f_flag = sel_flags.f;
endmodule

// File: rtl/efi_chk.sv
module efi_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic ext_h,
  input logic ext_v,
  input logic code_hit,
  input logic y_vld,
  input logic prot_err,
  input logic h_flag,
  input logic v_flag,
  input logic f_flag
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> !prot_err); // R5

  AST_FLAGS_HELD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_err && !sync_mode && !$past(sync_mode)) |-> $stable({f_flag, v_flag, h_flag})); // R5

  AST_CODE_NOT_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && code_hit) |=> (sync_mode || !y_vld)); // R4

  AST_EXT_FLAGS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> (!sync_mode || (h_flag == $past(ext_h) && v_flag == $past(ext_v)))); // R7

  AST_EXT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_mode) |-> !prot_err); // R7
endmodule

bind embsync_fmt efi_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_mode (sync_mode),
  .ext_h     (ext_h),
  .ext_v     (ext_v),
  .code_hit  (code_hit),
  .y_vld     (y_vld),
  .prot_err  (prot_err),
  .h_flag    (h_flag),
  .v_flag    (v_flag),
  .f_flag    (f_flag)
);

// File: tb/tb_embsync_fmt.sv
`timescale 1ns/1ps
module tb_embsync_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       narrow = 1'b0;
  logic [9:0] mux_data = '0;
  logic [9:0] luma_in = '0;
  logic [9:0] chroma_in = '0;
  logic       ext_h = 1'b0, ext_v = 1'b0, ext_f = 1'b0;
  logic [9:0] y_out, cb_out, cr_out;
  logic       y_vld, cb_vld, cr_vld, h_flag, v_flag, f_flag, prot_err;

  always #2.5 clk = ~clk;

  embsync_fmt dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .narrow(narrow),
    .mux_data(mux_data), .luma_in(luma_in), .chroma_in(chroma_in),
    .ext_h(ext_h), .ext_v(ext_v), .ext_f(ext_f),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .y_vld(y_vld), .cb_vld(cb_vld), .cr_vld(cr_vld),
    .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag), .prot_err(prot_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [29:0] expq [0:2047];
  int wr = 0, rd = 0;
  int seed = 1;
  logic [2:0] cur_fvh = 3'b000;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] vexp(input int s);
    if (narrow) return {8'(16 + (s % 200)), 2'b00};
    return 10'(64 + (s % 800));
  endfunction

  function automatic logic [3:0] pbits(input logic [2:0] fvh);
    logic f, v, h;
    {f, v, h} = fvh;
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Output monitor: R3 R8 ordering and values, strobes together
  always @(negedge clk) begin
    if (rst_n && y_vld) begin
      if (rd < wr) begin
        chk({y_out, cb_out, cr_out} == expq[rd], "R3/R8 pixel", {y_out, cb_out, cr_out}, expq[rd]);
        rd++;
      end else begin
        chk(1'b0, "R4/R6 unexpected pixel", {y_out, cb_out, cr_out}, 0);
      end
      chk(cb_vld && cr_vld, "R3 strobes together", {cb_vld, cr_vld}, 3);
    end
  end

  task automatic put(input logic [9:0] w10);
    mux_data = narrow ? {2'b10, w10[9:2]} : w10;
    @(negedge clk);
  endtask

  task automatic push(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr);
    expq[wr] = {y, cb, cr};
    wr++;
  endtask

  task automatic send_code(input logic [2:0] fvh, input bit bad);
    logic [9:0] st;
    st = {1'b1, fvh, pbits(fvh) ^ (bad ? 4'b0100 : 4'b0000), 2'b00};
    {ext_f, ext_v, ext_h} = ~fvh;   // R9: pins must not matter
    put(10'h3FF); put(10'h000); put(10'h000); put(st);
    if (!bad) cur_fvh = fvh;
    chk({f_flag, v_flag, h_flag} == cur_fvh, bad ? "R5 flags held" : "R1 R9 flags decoded",
        {f_flag, v_flag, h_flag}, cur_fvh);
    chk(prot_err == bad, "R5 prot_err", prot_err, bad);
  endtask

  task automatic send_pairs(input int n);
    logic [9:0] cb, y0, cr, y1;
    for (int k = 0; k < n; k++) begin
      cb = vexp(seed * 37 + 5); y0 = vexp(seed * 11 + 90);
      cr = vexp(seed * 53 + 17); y1 = vexp(seed * 29 + 140);
      seed++;
      push(y0, cb, cr); push(y1, cb, cr);
      put(cb); put(y0); put(cr); put(y1);
    end
  endtask

  task automatic do_reset(input bit mode, input bit nar);
    rst_n = 1'b0; sync_mode = mode; narrow = nar;
    repeat (3) @(negedge clk);
    chk({y_out, cb_out, cr_out, y_vld, cb_vld, cr_vld} == '0, "R10 reset outputs",
        {y_out, cb_out, cr_out}, 0);
    chk({h_flag, v_flag, f_flag, prot_err} == '0, "R10 reset flags", {h_flag, v_flag, f_flag, prot_err}, 0);
    cur_fvh = 3'b000;
    rst_n = 1'b1;
  endtask

  task automatic ext_cycle(input bit h, input bit v, input bit f, input logic [9:0] y, input logic [9:0] c);
    ext_h = h; ext_v = v; ext_f = f;
    luma_in   = narrow ? {2'b01, y[9:2]} : y;
    chroma_in = narrow ? {2'b01, c[9:2]} : c;
    @(negedge clk);
  endtask

  task automatic ext_line(input int np, input bit extra, input bit v, input bit f);
    logic [9:0] y, c, ya, cb;
    ya = '0; cb = '0;
    ext_cycle(1'b1, v, f, 10'h0, 10'h0);
    ext_cycle(1'b1, v, f, 10'h0, 10'h0);
    chk({f_flag, v_flag, h_flag} == {f, v, 1'b1}, "R7 pin flags", {f_flag, v_flag, h_flag}, {f, v, 1'b1});
    chk(prot_err == 1'b0, "R7 no error", prot_err, 0);
    for (int i = 0; i < 2 * np + int'(extra); i++) begin
      y = vexp(seed * 19 + i * 7 + 3);
      c = vexp(seed * 23 + i * 31 + 60);
      if (i % 2 == 0) begin ya = y; cb = c; end
      else begin push(ya, cb, c); push(y, cb, c); end
      ext_cycle(1'b0, v, f, y, c);
    end
    seed++;
    ext_cycle(1'b1, v, f, 10'h0, 10'h0);
    // Same cycle: h_flag rises while the last luma sample is emitted
    chk(h_flag == 1'b1, "R8 h_flag with last pixel", h_flag, 1);
    chk(y_vld == (np > 0 && !extra), "R8 last pixel valid", y_vld, (np > 0 && !extra));
    ext_cycle(1'b1, v, f, 10'h0, 10'h0);
  endtask

  initial begin
    for (int nar = 0; nar < 2; nar++) begin
      // Embedded mode sweep: all flag combinations, R1 R2 R3
      do_reset(1'b0, nar[0]);
      for (int fvh = 0; fvh < 8; fvh++) begin
        send_code(3'(fvh), 1'b0);
        send_pairs(1 + fvh % 3);
        send_code(3'(fvh + 3), 1'b1);   // R5 bad protection
        send_pairs(2);
      end
      // R6: two-word partial pair emits nothing
      send_code(3'b101, 1'b0);
      put(vexp(900)); put(vexp(901));
      send_code(3'b010, 1'b0);
      send_pairs(1);
      // R6: three-word partial pair emits only the first pixel
      send_code(3'b110, 1'b0);
      push(vexp(911), vexp(910), vexp(912));
      put(vexp(910)); put(vexp(911)); put(vexp(912));
      send_code(3'b001, 1'b0);
      send_pairs(2);
      send_code(3'b000, 1'b0);
      chk(rd == wr, "R4 R6 all embedded pixels seen", rd, wr);
    end

    for (int nar = 0; nar < 2; nar++) begin
      do_reset(1'b1, nar[0]);
      // R7: codes on mux_data are ignored in external mode
      mux_data = 10'h3FF; ext_cycle(1'b0, 1'b1, 1'b0, 10'h100, 10'h100);
      mux_data = 10'h000; ext_cycle(1'b1, 1'b1, 1'b0, 10'h100, 10'h100);
      mux_data = 10'h000; ext_cycle(1'b1, 1'b1, 1'b0, 10'h100, 10'h100);
      mux_data = 10'h2D0; ext_cycle(1'b1, 1'b0, 1'b1, 10'h100, 10'h100);
      chk({f_flag, v_flag, h_flag} == 3'b101, "R7 codes ignored", {f_flag, v_flag, h_flag}, 3'b101);
      chk(prot_err == 1'b0, "R7 no error on codes", prot_err, 0);
      // R2: 1 pixel was produced by the stray active cycle? pairing needs two cycles: none
      chk(rd == wr, "R8 lone Cb dropped", rd, wr);
      for (int ln = 0; ln < 8; ln++)
        ext_line(ln % 5, ln[0] & ln[1], ln[1], ln[2]);
      repeat (2) @(negedge clk);
      chk(rd == wr, "R8 all external pixels seen", rd, wr);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule